// File: doc/BRIEF.md
# Serial Dot-Matrix Panel Scan Controller

This block keeps a monochrome dot-matrix panel refreshed without help from software. Row after row, it fetches one row of pixels from a frame buffer through a simple synchronous read port. It shifts that row out one bit per dot-clock period, leftmost pixel first. Between rows it opens a blanking window. In that window it pulses the transparent column latch, then advances the panel's row scan with one row-clock pulse and a first-row marker.

The display-enable output gates the panel drivers. It is held low through the whole blanking window. Outside that window it is high for an on-time set by a brightness input, which gives duty-cycle dimming. The next row is shifted in while the current row is shown. Dot-clock and blanking lengths come from parameterised counts of the system clock. The on-time slot is the shift time, rounded up to a whole number of brightness steps.

Top module: `panel_scan_ctrl`

## Requirements
- R1: Between two consecutive rising edges of the column latch, and before the first one after reset, the dot clock shows exactly COLS rising edges.
- R2: Bit k of the frame-buffer word, where bit 0 is the leftmost column, is presented on the serial data output at the k-th dot-clock rising edge of its row. Serial data is held steady at each rising edge, and a 1 means a lit pixel.
- R3: The column latch goes high exactly once per row period. The dot clock stays low and no shift is in progress while the latch is high.
- R4: Display enable is low in the cycle of every column-latch or row-clock level change and in the cycle before it. Every low interval of display enable lasts at least BLANK_CYC system clocks.
- R5: Rows are scanned in the order 0, 1, … ROWS-1 and then wrap to 0. The first-row marker is 1 at the row-clock falling edge of row 0 and 0 at the falling edge of every other row. The first row after reset is row 0.
- R6: Let U be ceil((2·DOT_DIV·COLS+4) / 2^BRT_W). In each row period, display enable is high for exactly brightness·U system clocks. The brightness value is sampled once, when the on-time starts, so a change made later in that row has no effect until the next row.
- R7: Each row fetch is a single-cycle read-enable pulse. The read address carries the row to be shifted, the data is taken one cycle later, and the addresses follow the row order of R5, starting with 0 after reset.
- R8: While reset is low, and in the first cycle after it is sampled low, every panel output and the read enable are 0.
- R9: The row clock pulses once per row period. Its falling edges are exactly BLANK_CYC + 2^BRT_W·U system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_bright | input | BRT_W | Brightness setting, on-time in units of U cycles |
| i_fb_rd_data | input | COLS | Frame-buffer row word, bit 0 = leftmost pixel |
| o_fb_rd_en | output | 1 | Frame-buffer read enable |
| o_fb_rd_addr | output | clog2(ROWS) | Frame-buffer row address |
| o_dot_clk | output | 1 | Panel dot clock |
| o_ser_data | output | 1 | Panel serial pixel data |
| o_col_latch | output | 1 | Panel column latch, transparent while high |
| o_disp_en | output | 1 | Panel driver enable and dimming |
| o_row_clk | output | 1 | Panel row-scan clock, sampled on its falling edge |
| o_row_first | output | 1 | First-row marker |

## Verification
The assertions assume a frame buffer that returns the addressed row one cycle after the read enable. They also assume that BLANK_CYC is at least 4, so each quarter of the blanking window is at least one cycle long. The bench keeps a one-cycle registered row store and uses a blanking count of 12. It changes brightness only at negedge sampling points, and it drops reset only on a falling clock edge. Under those conditions, the dark-window and shift-fit checks cover every row the bench drives.

// File: rtl/panel_scan_pkg.sv
// Shared state encodings for the panel scan controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package panel_scan_pkg;
    typedef enum logic [1:0] {
        SEQ_PRIME,
        SEQ_BLANK,
        SEQ_ON
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_FETCH,
        SH_CAPT,
        SH_SHIFT
    } sh_state_t;
endpackage

// File: rtl/panel_dot_shifter.sv
// Fetches one row word from the frame buffer and sends it serially, bit 0
// first, with a divided dot clock. Serial data changes only on dot-clock
// falling edges. Assumes read data is valid one cycle after the read enable.
module panel_dot_shifter
    import panel_scan_pkg::*;
#(
    parameter int COLS    = 256,
    parameter int ROWS    = 64,
    parameter int DOT_DIV = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_start,
    input  logic [RW-1:0]   i_row,
    input  logic [COLS-1:0] i_fb_rd_data,
    output logic            o_busy,
    output logic            o_fb_rd_en,
    output logic [RW-1:0]   o_fb_rd_addr,
    output logic            o_dclk,
    output logic            o_sdata
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int DW = (DOT_DIV > 1) ? $clog2(DOT_DIV) : 1;
    localparam int BW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DOT_DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(COLS - 1);

    sh_state_t       st;
    logic [COLS-1:0] sr;
    logic [DW-1:0]   div;
    logic [BW-1:0]   bitc;
    logic [RW-1:0]   addr_q;
    logic            dclk_q;

    // Fetch, capture and dot-rate shift sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SH_IDLE;
            sr     <= '0;
            div    <= '0;
            bitc   <= '0;
            addr_q <= '0;
            dclk_q <= 1'b0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (i_start) begin
                        addr_q <= i_row;
                        st     <= SH_FETCH;
                    end
                end
                SH_FETCH: st <= SH_CAPT;
                SH_CAPT: begin
                    sr     <= i_fb_rd_data;
                    div    <= '0;
                    bitc   <= '0;
                    dclk_q <= 1'b0;
                    st     <= SH_SHIFT;
                end
                default: begin
                    if (div == DIV_LAST) begin
                        div <= '0;
                        if (!dclk_q) begin
                            dclk_q <= 1'b1;
                        end else begin
                            dclk_q <= 1'b0;
                            sr     <= sr >> 1;
                            if (bitc == BIT_LAST) st <= SH_IDLE;
                            else                  bitc <= bitc + 1'b1;
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            endcase
        end
    end

    assign o_busy       = (st != SH_IDLE);
    assign o_fb_rd_en   = (st == SH_FETCH);
    assign o_fb_rd_addr = addr_q;
    assign o_dclk       = dclk_q;
    assign o_sdata      = sr[0];

    AST_ONE_CYCLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        o_fb_rd_en |=> !o_fb_rd_en); // R7
    AST_SDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_dclk) |-> $stable(o_sdata)); // R2
endmodule

// File: rtl/panel_row_seq.sv
// Row-period sequencer: a blanking window (latch pulse, then row-clock pulse
// with first-row marker) followed by an on-time slot with brightness-scaled
// enable. Starts the shift of the next row at the start of each on-time.
// Assumes BLANK_CYC >= 4 and a shifter that finishes within 2*DOT_DIV*COLS+4.
module panel_row_seq
    import panel_scan_pkg::*;
#(
    parameter int COLS      = 256,
    parameter int ROWS      = 64,
    parameter int DOT_DIV   = 16,
    parameter int BLANK_CYC = 1250,
    parameter int BRT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRT_W-1:0] i_bright,
    input  logic             i_sh_busy,
    output logic             o_sh_start,
    output logic [RW-1:0]    o_row,
    output logic             o_col_latch,
    output logic             o_row_clk,
    output logic             o_row_first,
    output logic             o_disp_en
);
    localparam int RW        = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int SHIFT_CYC = 2 * DOT_DIV * COLS + 4;
    localparam int STEPS     = 2 ** BRT_W;
    localparam int ON_UNITS  = (SHIFT_CYC + STEPS - 1) / STEPS;
    localparam int ON_CYC    = ON_UNITS * STEPS;
    localparam int QTR       = BLANK_CYC / 4;
    localparam int MAXC      = (ON_CYC > BLANK_CYC) ? ON_CYC : BLANK_CYC;
    localparam int CW        = $clog2(MAXC + 1);
    localparam logic [CW-1:0] Q1      = CW'(QTR);
    localparam logic [CW-1:0] Q2      = CW'(2 * QTR);
    localparam logic [CW-1:0] Q3      = CW'(3 * QTR);
    localparam logic [CW-1:0] B_LAST  = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] ON_LAST = CW'(ON_CYC - 1);
    localparam logic [CW-1:0] UNIT    = CW'(ON_UNITS);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

    seq_state_t       st;
    logic [CW-1:0]    cnt;
    logic [RW-1:0]    row_q;
    logic [BRT_W-1:0] brt_q;
    logic             start_q;
    logic [CW-1:0]    on_len;

    assign on_len = CW'(brt_q) * UNIT;

    // Phase and counter progression through prime, blank and on-time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SEQ_PRIME;
            cnt     <= '0;
            row_q   <= '0;
            brt_q   <= '0;
            start_q <= 1'b1;
        end else begin
            start_q <= 1'b0;
            case (st)
                SEQ_PRIME: begin
                    if (cnt >= CW'(2) && !i_sh_busy) begin
                        st  <= SEQ_BLANK;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_BLANK: begin
                    if (cnt == B_LAST) begin
                        st      <= SEQ_ON;
                        cnt     <= '0;
                        brt_q   <= i_bright;
                        start_q <= 1'b1;
                        row_q   <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == ON_LAST) begin
                        st  <= SEQ_BLANK;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Registered panel control decode, all outputs delayed equally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_col_latch <= 1'b0;
            o_row_clk   <= 1'b0;
            o_row_first <= 1'b0;
            o_disp_en   <= 1'b0;
        end else begin
            o_col_latch <= (st == SEQ_BLANK) && (cnt >= Q1) && (cnt < Q2);
            o_row_clk   <= (st == SEQ_BLANK) && (cnt >= Q2) && (cnt < Q3);
            o_row_first <= (st == SEQ_BLANK) && (row_q == '0);
            o_disp_en   <= (st == SEQ_ON) && (cnt < on_len);
        end
    end

    assign o_sh_start = start_q;
    assign o_row      = row_q;

    AST_LATCH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (o_col_latch != $past(o_col_latch)) |-> (!o_disp_en && !$past(o_disp_en))); // R4
    AST_RCLK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (o_row_clk != $past(o_row_clk)) |-> (!o_disp_en && !$past(o_disp_en))); // R4
    AST_SHIFT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_ON && cnt == ON_LAST) |-> !i_sh_busy); // R1
endmodule

// File: rtl/panel_scan_ctrl.sv
// Top of the panel scan controller: joins the row sequencer and the dot
// shifter. Assumes a one-cycle-latency synchronous frame-buffer read port.
module panel_scan_ctrl #(
    parameter int COLS      = 256,
    parameter int ROWS      = 64,
    parameter int DOT_DIV   = 16,
    parameter int BLANK_CYC = 1250,
    parameter int BRT_W     = 4,
    localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRT_W-1:0] i_bright,
    input  logic [COLS-1:0]  i_fb_rd_data,
    output logic             o_fb_rd_en,
    output logic [RW-1:0]    o_fb_rd_addr,
    output logic             o_dot_clk,
    output logic             o_ser_data,
    output logic             o_col_latch,
    output logic             o_disp_en,
    output logic             o_row_clk,
    output logic             o_row_first
);
    logic          sh_start;
    logic          sh_busy;
    logic [RW-1:0] sh_row;

    panel_row_seq #(
        .COLS(COLS), .ROWS(ROWS), .DOT_DIV(DOT_DIV),
        .BLANK_CYC(BLANK_CYC), .BRT_W(BRT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .i_bright(i_bright),
        .i_sh_busy(sh_busy), .o_sh_start(sh_start), .o_row(sh_row),
        .o_col_latch(o_col_latch), .o_row_clk(o_row_clk),
        .o_row_first(o_row_first), .o_disp_en(o_disp_en)
    );

    panel_dot_shifter #(
        .COLS(COLS), .ROWS(ROWS), .DOT_DIV(DOT_DIV)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .i_start(sh_start), .i_row(sh_row),
        .i_fb_rd_data(i_fb_rd_data), .o_busy(sh_busy),
        .o_fb_rd_en(o_fb_rd_en), .o_fb_rd_addr(o_fb_rd_addr),
        .o_dclk(o_dot_clk), .o_sdata(o_ser_data)
    );

    AST_NO_DOT_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        o_col_latch |-> (!sh_busy && !o_dot_clk)); // R3
endmodule

// File: tb/panel_scan_ctrl_tb.sv
// Bench: panel model (shift register, latch, row counter), frame-buffer
// model, brightness vector table, then directed reset and corner tests.
module panel_scan_ctrl_tb;
    localparam int COLS = 16;
    localparam int ROWS = 4;
    localparam int DDIV = 2;
    localparam int BLNK = 12;
    localparam int BW   = 4;
    localparam int U    = 5;            // ceil((2*2*16+4)/16)
    localparam int ROW_PER = BLNK + 16 * U;

    // {brightness, expected enable-high cycles per row}
    localparam logic [11:0] VEC [5] = '{
        {4'd0, 8'd0}, {4'd1, 8'd5}, {4'd8, 8'd40}, {4'd15, 8'd75}, {4'd3, 8'd15}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [BW-1:0]   bright = '0;
    logic [COLS-1:0] fb_data = '0;
    logic            rd_en, dclk, sdata, latch, en, rclk, rfirst;
    logic [1:0]      rd_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    panel_scan_ctrl #(
        .COLS(COLS), .ROWS(ROWS), .DOT_DIV(DDIV), .BLANK_CYC(BLNK), .BRT_W(BW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .i_bright(bright), .i_fb_rd_data(fb_data),
        .o_fb_rd_en(rd_en), .o_fb_rd_addr(rd_addr), .o_dot_clk(dclk),
        .o_ser_data(sdata), .o_col_latch(latch), .o_disp_en(en),
        .o_row_clk(rclk), .o_row_first(rfirst)
    );

    function automatic logic [COLS-1:0] img(input logic [1:0] a);
        case (a)
            2'd0:    return 16'h0001;
            2'd1:    return 16'hFFFF;
            2'd2:    return 16'h0000;
            default: return 16'hA5C3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Frame-buffer model: registered read, one cycle latency.
    always @(posedge clk) if (rd_en) fb_data <= img(rd_addr);

    // Panel and timing monitor state.
    logic            p_dclk, p_latch, p_rclk, p_en;
    logic [COLS-1:0] pan_sr;
    int dot_cnt, lat_row, cur_row, on_acc, last_on, latch_rises;
    int low_run, fall_cnt, since_fall, first_cnt, exp_addr;
    bit have_fall, last_rfirst;

    // Panel model sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            p_dclk = 0; p_latch = 0; p_rclk = 0; p_en = 0; pan_sr = '0;
            dot_cnt = 0; lat_row = 0; cur_row = 0; on_acc = 0;
            low_run = 0; since_fall = 0; have_fall = 0; exp_addr = 0;
        end else begin
            if (rd_en) begin
                chk(int'(rd_addr) == exp_addr, "R7", int'(rd_addr), exp_addr);
                exp_addr = (exp_addr + 1) % ROWS;
            end
            if (dclk && !p_dclk) begin
                chk(!latch, "R3", int'(latch), 0);
                pan_sr = {sdata, pan_sr[COLS-1:1]};
                dot_cnt++;
            end
            if (latch != p_latch)
                chk(!en && !p_en, "R4", int'(en | p_en), 0);
            if (rclk != p_rclk)
                chk(!en && !p_en, "R4", int'(en | p_en), 0);
            if (latch && !p_latch) begin
                chk(dot_cnt == COLS, "R1", dot_cnt, COLS);
                chk(pan_sr == img(2'(lat_row)), "R2", int'(pan_sr), int'(img(2'(lat_row))));
                cur_row = lat_row;
                lat_row = (lat_row + 1) % ROWS;
                dot_cnt = 0;
                last_on = on_acc;
                on_acc  = 0;
                latch_rises++;
            end
            since_fall++;
            if (!rclk && p_rclk) begin
                chk(rfirst == (cur_row == 0), "R5", int'(rfirst), int'(cur_row == 0));
                if (have_fall) chk(since_fall == ROW_PER, "R9", since_fall, ROW_PER);
                have_fall = 1;
                since_fall = 0;
                last_rfirst = rfirst;
                if (rfirst) first_cnt++;
                fall_cnt++;
            end
            if (en && !p_en) chk(low_run >= BLNK, "R4", low_run, BLNK);
            if (en) begin on_acc++; low_run = 0; end
            else low_run++;
            p_dclk = dclk; p_latch = latch; p_rclk = rclk; p_en = en;
        end
    end

    task automatic wait_rises(input int n);
        int target = latch_rises + n;
        while (latch_rises < target) @(negedge clk);
    endtask

    task automatic outputs_zero(input string tag);
        int v = int'({rd_en, dclk, sdata, latch, en, rclk, rfirst});
        chk(v == 0, tag, v, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int base, seen;
        repeat (4) @(negedge clk);
        outputs_zero("R8");                      // reset state
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge clk);
            if (rd_en) seen = 1;
        end
        chk(seen == 1, "R7", seen, 1);           // prime fetch of row 0

        for (int i = 0; i < 5; i++) begin        // brightness vectors (R6)
            bright = VEC[i][11:8];
            wait_rises(2);
            chk(last_on == int'(VEC[i][7:0]), "R6", last_on, int'(VEC[i][7:0]));
        end

        bright = 4'd4;                           // mid-row change ignored (R6)
        wait_rises(2);
        while (!en) @(negedge clk);
        bright = 4'd15;
        wait_rises(1);
        chk(last_on == 20, "R6", last_on, 20);
        wait_rises(1);
        chk(last_on == 75, "R6", last_on, 75);

        base = first_cnt;                        // wrap over two frames (R5)
        wait_rises(2 * ROWS);
        chk(first_cnt - base == 2, "R5", first_cnt - base, 2);

        while (!en) @(negedge clk);              // reset while lit (R8)
        rst_n = 1'b0;
        @(negedge clk);
        outputs_zero("R8");
        rst_n = 1'b1;
        base = fall_cnt;
        while (fall_cnt == base) @(negedge clk);
        chk(last_rfirst == 1, "R5", int'(last_rfirst), 1);
        wait_rises(ROWS);
        finish_run();
    end
endmodule